// File: doc/BRIEF.md
# Multi-Depth Luma Overlay Serializer

This block takes a single-bit serial stream from an external memory and turns it into overlay pixels that brighten a host video luminance code. It runs on a pixel clock at four times the color clock and phase-locked to it, so every color clock carries exactly four stream bits. A mode input chooses how those four bits are used. There can be four one-bit pixels, two two-bit pixels or one four-bit pixel per color clock, which gives 640, 320 or 160 pixels across an active line.

A pixel value of zero is transparent, so the host luma passes through unchanged. A non-zero pixel is scaled to the full 4-bit luma range and added to the host code. The sum clips at the top code. The readout enable is driven high only across the 192 active scan lines, and whenever it is low the overlay is forced transparent. Memory addressing, sync generation and analog mixing are handled outside the block.

Top module: `luma_overlay_ser`

## Requirements
- R1: While `rst` is high at a clock edge, `luma_out` and the internal pixel clear to 0. The phase counter returns to 3, so the first cycle after reset is phase 0 even without a strobe.
- R2: In mode 2'b00 each stream bit forms one pixel. A 1 maps to overlay code 15 and a 0 is transparent, and the pixel updates every cycle.
- R3: In mode 2'b01 bits are paired MSB first, with the earlier bit as the high bit. A pair value v becomes overlay code 5*v. The pixel updates only in phases 1 and 3, using the bits of phases 0-1 and 2-3.
- R4: In mode 2'b10 four bits form one pixel MSB first, with the phase 0 bit as bit 3. The pixel updates only in phase 3.
- R5: `cc_phase` high marks the current cycle as phase 0. Otherwise the phase advances by one modulo 4 each cycle, and a strobe in mid color clock restarts the count.
- R6: When the pixel is 0, `luma_out` equals the host luma.
- R7: When the pixel is non-zero, `luma_out` is the host luma plus the pixel, clipped at 15 instead of wrapping.
- R8: When `rd_en` is low in a cycle, the pixel becomes 0 at the following edge. This takes precedence over any mode update due in that cycle.
- R9: Mode 2'b11 is reserved, and the pixel becomes 0 while it is selected.
- R10: A bit presented in cycle n affects the pixel from cycle n+1. The `luma_out` of cycle n+2 combines that pixel with the host luma presented in cycle n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, four times the color clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Serial overlay data bit |
| cc_phase | input | 1 | Color-clock phase-0 strobe |
| mode | input | 2 | Pixel depth select |
| rd_en | input | 1 | Readout enable, high across active lines |
| host_luma | input | 4 | Host video luma code |
| luma_out | output | 4 | Summed luma code, registered |

## Verification
Two things can fall in the same cycle. A pixel boundary, phase 3 in mode 2'b10 or phase 1 in mode 2'b01, can arrive in the cycle where `rd_en` drops. The bench lowers the enable on exactly such a boundary with a non-zero pattern in flight and expects the host luma to pass unchanged in the following cycle. It also drives pixel 15 over host 15 in the same stretch so that clipping and transparency meet back to back.

// File: rtl/luma_ovl_pkg.sv
package luma_ovl_pkg;
  localparam int LUMA_W = 4;
  localparam int PH_W   = 2;

  typedef enum logic [1:0] {
    MODE_MONO = 2'b00,
    MODE_QUAD = 2'b01,
    MODE_HEX  = 2'b10,
    MODE_RSVD = 2'b11
  } ovl_mode_e;
endpackage

// File: rtl/ovl_bit_gather.sv
module ovl_bit_gather #(
  parameter int WIN_W = 4,
  parameter int PH_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_bit,
  input  logic             cc_phase,
  output logic [WIN_W-1:0] win,
  output logic [PH_W-1:0]  phase_now
);
  logic [WIN_W-2:0] hist_q;
  logic [PH_W-1:0]  ph_q;

  // current window: older bits high, newest bit low
  assign win       = {hist_q, ser_bit};
  assign phase_now = cc_phase ? '0 : ph_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      ph_q   <= '1;
    end else begin
      hist_q <= win[WIN_W-2:0];
      ph_q   <= phase_now;
    end
  end
endmodule

// File: rtl/ovl_pixel_former.sv
module ovl_pixel_former
  import luma_ovl_pkg::*;
#(
  parameter int LUMA_W = 4,
  parameter int PH_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              rd_en,
  input  logic [LUMA_W-1:0] win,
  input  logic [PH_W-1:0]   phase_now,
  output logic [LUMA_W-1:0] pix_q
);
  localparam int PAIRS = LUMA_W / 2;

  ovl_mode_e         sel;
  logic [LUMA_W-1:0] mono_px, quad_px, hex_px;
  logic [LUMA_W-1:0] pix_d;

  assign sel     = ovl_mode_e'(mode);
  assign mono_px = {LUMA_W{win[0]}};
  assign hex_px  = win;

  // two-bit code replicated across the word scales v to full range
  genvar g;
  generate
    for (g = 0; g < PAIRS; g++) begin : g_rep
      assign quad_px[2*g+1 -: 2] = win[1:0];
    end
  endgenerate

  always_comb begin
    pix_d = pix_q;
    if (!rd_en) begin
      pix_d = '0;
    end else begin
      unique case (sel)
        MODE_MONO: pix_d = mono_px;
        MODE_QUAD: if (phase_now[0]) pix_d = quad_px;
        MODE_HEX:  if (&phase_now)   pix_d = hex_px;
        default:   pix_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pix_q <= '0;
    else     pix_q <= pix_d;
  end
endmodule

// File: rtl/ovl_luma_summer.sv
module ovl_luma_summer #(
  parameter int LUMA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LUMA_W-1:0] pix,
  input  logic [LUMA_W-1:0] host,
  output logic [LUMA_W-1:0] luma_q
);
  logic [LUMA_W:0]   sum;
  logic [LUMA_W-1:0] clipped;

  assign sum     = {1'b0, host} + {1'b0, pix};
  assign clipped = sum[LUMA_W] ? '1 : sum[LUMA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)             luma_q <= '0;
    else if (pix == '0)  luma_q <= host;
    else                 luma_q <= clipped;
  end
endmodule

// File: rtl/luma_overlay_ser.sv
module luma_overlay_ser
  import luma_ovl_pkg::*;
#(
  parameter int LW = LUMA_W,
  parameter int PW = PH_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_bit,
  input  logic          cc_phase,
  input  logic [1:0]    mode,
  input  logic          rd_en,
  input  logic [LW-1:0] host_luma,
  output logic [LW-1:0] luma_out
);
  logic [LW-1:0] win;
  logic [PW-1:0] phase_now;
  logic [LW-1:0] pix_q;

  ovl_bit_gather #(.WIN_W(LW), .PH_W(PW)) u_gather (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .cc_phase(cc_phase),
    .win(win), .phase_now(phase_now)
  );

  ovl_pixel_former #(.LUMA_W(LW), .PH_W(PW)) u_former (
    .clk(clk), .rst(rst), .mode(mode), .rd_en(rd_en),
    .win(win), .phase_now(phase_now), .pix_q(pix_q)
  );

  ovl_luma_summer #(.LUMA_W(LW)) u_sum (
    .clk(clk), .rst(rst), .pix(pix_q), .host(host_luma), .luma_q(luma_out)
  );
endmodule

// File: rtl/luma_overlay_chk.sv
module luma_overlay_chk #(
  parameter int LW = 4,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ser_bit,
  input logic [1:0]    mode,
  input logic          rd_en,
  input logic [LW-1:0] host_luma,
  input logic [LW-1:0] luma_out,
  input logic [LW-1:0] pix,
  input logic [PW-1:0] phase
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (luma_out == '0) && (pix == '0));

  p_mono_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mode == 2'b00) |=> (pix == {LW{$past(ser_bit)}}));

  p_quad_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mode == 2'b01 && !phase[0]) |=> $stable(pix));

  p_hex_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mode == 2'b10 && !(&phase)) |=> $stable(pix));

  p_transparent_r6: assert property (@(posedge clk) disable iff (rst)
    (pix == '0) |=> (luma_out == $past(host_luma)));

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (pix != '0) |=> (luma_out >= $past(host_luma)) && (luma_out >= $past(pix)));

  p_gate_off_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (pix == '0));

  p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (pix == '0));
endmodule

bind luma_overlay_ser luma_overlay_chk #(.LW(LW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .ser_bit(ser_bit), .mode(mode), .rd_en(rd_en),
  .host_luma(host_luma), .luma_out(luma_out), .pix(pix_q), .phase(phase_now)
);

// File: tb/luma_overlay_ser_test.sv
`timescale 1ns/1ps
module luma_overlay_ser_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_bit = 1'b0;
  logic       cc_phase = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       rd_en = 1'b0;
  logic [3:0] host_luma = 4'd0;
  logic [3:0] luma_out;

  int checks = 0;
  int errors = 0;

  // bench-side expectation state
  logic [3:0] exp_pix = 4'd0;
  logic [1:0] ph_m = 2'd3;
  logic [3:0] hist = 4'd0;

  always #2.5 clk = ~clk;

  luma_overlay_ser uut (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .cc_phase(cc_phase),
    .mode(mode), .rd_en(rd_en), .host_luma(host_luma), .luma_out(luma_out)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one pixel-clock cycle: drive at negedge, check output at next negedge
  task automatic step(input logic b, input logic stb, input logic [1:0] m,
                      input logic en, input logic [3:0] h, input string tag);
    logic [3:0] nxt;
    logic [3:0] eo;
    int s;
    ph_m = stb ? 2'd0 : ph_m + 2'd1;
    hist = {hist[2:0], b};
    nxt = exp_pix;
    if (!en) nxt = 4'd0;
    else case (m)
      2'b00: nxt = b ? 4'd15 : 4'd0;
      2'b01: if (ph_m[0]) nxt = 4'(hist[1:0] * 5);
      2'b10: if (ph_m == 2'd3) nxt = hist;
      default: nxt = 4'd0;
    endcase
    s = int'(h) + int'(exp_pix);
    eo = (exp_pix == 0) ? h : ((s > 15) ? 4'd15 : 4'(s));
    ser_bit = b; cc_phase = stb; mode = m; rd_en = en; host_luma = h;
    @(posedge clk);
    @(negedge clk);
    check(luma_out, eo, tag);
    exp_pix = nxt;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, and host passes straight after reset
    rst = 1'b1; host_luma = 4'd9; ser_bit = 1'b1; rd_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(luma_out, 4'd0, "R1 reset");
    rst = 1'b0;
    step(1'b0, 1'b0, 2'b10, 1'b1, 4'd7, "R1 after reset");

    // R2: one-bit pixels over every host level
    for (int i = 0; i < 64; i++)
      step(i[0] ^ i[2], (i % 4) == 0, 2'b00, 1'b1, 4'(i), "R2 mono");

    // R10: single bit impulse latency in mode 0
    step(1'b0, 1'b1, 2'b00, 1'b1, 4'd2, "R10 pre");
    step(1'b1, 1'b0, 2'b00, 1'b1, 4'd2, "R10 bit");
    step(1'b0, 1'b0, 2'b00, 1'b1, 4'd3, "R10 pix");
    step(1'b0, 1'b0, 2'b00, 1'b1, 4'd4, "R10 out");

    // R3: every pair value against swept host levels
    for (int i = 0; i < 128; i++)
      step(i[3] ^ i[0], (i % 4) == 0, 2'b01, 1'b1, 4'(i * 3), "R3 quad");

    // R4 R7: all 16 four-bit pixels, including 15 over 15
    for (int v = 0; v < 16; v++)
      for (int k = 0; k < 4; k++)
        step(v[3-k], k == 0, 2'b10, 1'b1, 4'(v * 5 + k), "R4 R7 hex");
    for (int k = 0; k < 8; k++)
      step(1'b1, (k % 4) == 0, 2'b10, 1'b1, 4'd15, "R7 clip");

    // R5: strobe in mid color clock restarts phase
    for (int i = 0; i < 40; i++)
      step(i[1] | i[4], (i % 7) == 0, 2'b10, 1'b1, 4'(i), "R5 restrobe");
    for (int i = 0; i < 24; i++)
      step(i[0], (i % 5) == 0, 2'b01, 1'b1, 4'(15 - i), "R5 quad restrobe");

    // R6: all-zero stream is transparent
    for (int i = 0; i < 16; i++)
      step(1'b0, (i % 4) == 0, 2'b10, 1'b1, 4'(i), "R6 transparent");

    // R8: enable drops on the hex boundary with pattern 1111 in flight
    step(1'b1, 1'b1, 2'b10, 1'b1, 4'd1, "R8 setup");
    step(1'b1, 1'b0, 2'b10, 1'b1, 4'd1, "R8 setup");
    step(1'b1, 1'b0, 2'b10, 1'b1, 4'd1, "R8 setup");
    step(1'b1, 1'b0, 2'b10, 1'b0, 4'd6, "R8 collide");
    step(1'b1, 1'b1, 2'b10, 1'b0, 4'd6, "R8 gated");
    for (int i = 0; i < 16; i++)
      step(1'b1, (i % 4) == 0, 2'b00, 1'b0, 4'(i), "R8 blank");

    // R9: reserved mode is transparent
    for (int i = 0; i < 12; i++)
      step(1'b1, (i % 4) == 0, 2'b11, 1'b1, 4'(i), "R9 reserved");

    // R1: mid-run reset clears output
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(luma_out, 4'd0, "R1 midrun");
    @(posedge clk); @(negedge clk);
    check(luma_out, 4'd0, "R1 midrun hold");
    rst = 1'b0;
    exp_pix = 4'd0; ph_m = 2'd3; hist = 4'd0;
    for (int i = 0; i < 8; i++)
      step(1'b1, 1'b0, 2'b10, 1'b1, 4'd2, "R1 R5 phase after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule